// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block works out the order of column addresses for a single DDR memory burst. A command side hands it a starting column, a burst length code and an ordering choice. On every following clock it emits one column address with a valid strobe, and it flags the final beat of the burst. The low bits of the column, as many as the logarithm of the burst length, rotate through the burst. They either count upward and wrap, or they are XORed with the beat index. The higher column bits pass through unchanged.

A controller places the block between command decode and the array access path. A burst-stop input cuts the current burst short. A fresh start drops whatever burst is in progress and begins again from the new column. That start may come in the middle of a burst or on the final beat, which gives gapless back-to-back bursts.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held, and after it is released with no start, `beat_valid` and `beat_last` are 0 and `col_out` is 0.
- R2: A start sampled at a clock edge makes `beat_valid` 1 from the following cycle onward, and the first beat carries `start_col` unchanged.
- R3: The length code `len_code` selects the burst length: 0 gives 2 beats, 1 gives 4, 2 gives 8 and 3 gives 16. With no stop and no new start, `beat_valid` stays high for exactly that many consecutive cycles.
- R4: With `order_ilv` = 0 (sequential), beat i carries low bits equal to (start low bits + i) modulo the length. For example, start 5 with length 8 gives 5,6,7,0,1,2,3,4.
- R5: With `order_ilv` = 1 (interleaved), beat i carries low bits equal to the start low bits XOR i. For example, start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R6: Column bits at and above position log2(length) keep the values they had in `start_col` on every beat of the burst.
- R7: `beat_last` is 1 only on the final beat of a burst, and only while `beat_valid` is 1.
- R8: `burst_stop` sampled while a beat is being output, with no start at the same edge, makes `beat_valid` 0 in the next cycle. `burst_stop` has no effect while the block is idle.
- R9: A start sampled during a burst, including during its final beat, restarts the sequence at the new column in the next cycle, with the new length and ordering.
- R10: When start and `burst_stop` are sampled at the same edge, the start wins and a new burst begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst with the values on `start_col`, `len_code` and `order_ilv` |
| start_col | input | COL_W (9) | Starting column address |
| len_code | input | LEN_W (2) | Burst length code: 0→2, 1→4, 2→8, 3→16 |
| order_ilv | input | 1 | 0 = sequential wrap, 1 = interleaved XOR |
| burst_stop | input | 1 | Terminate the current burst after the beat now being output |
| col_out | output | COL_W (9) | Column address of the current beat |
| beat_valid | output | 1 | A beat is present on `col_out` |
| beat_last | output | 1 | Final beat of the burst |

## Verification
The assertions check these properties on every cycle: the first beat after a start equals the requested column, and the high column bits stay put across a running burst. They also check that a last beat, or a stop without a start, is followed by an idle cycle, that a start beats a simultaneous stop, and that the last flag never appears without a valid beat. The full address order for each length and ordering, the exact burst duration, and restarts at different beats can only be shown by the bench. It replays its scenarios against a behavioural model that computes each beat from modular arithmetic and compares the outputs on every clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Ordering applied to the low column bits of a burst.
    typedef enum logic {
        ORDER_SEQ = 1'b0,
        ORDER_ILV = 1'b1
    } order_e;

endpackage

// File: rtl/burst_len_mask.sv
// Turns a length code into a mask of the column bits that rotate.
module burst_len_mask #(
    parameter int LEN_W = 2,
    localparam int ORD_W = 2 ** LEN_W
) (
    input  logic [LEN_W-1:0] len_code,
    output logic [ORD_W-1:0] ord_mask
);

    // Code c gives length 2^(c+1), so bits 0..c take part in the ordering.
    for (genvar j = 0; j < ORD_W; j++) begin : g_bit
        assign ord_mask[j] = (len_code >= LEN_W'(j));
    end

endmodule

// File: rtl/burst_beat_ctr.sv
// Holds the burst-active flag and the beat index.
module burst_beat_ctr #(
    parameter int ORD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             halt,
    input  logic [ORD_W-1:0] ord_mask,
    output logic             active,
    output logic [ORD_W-1:0] beat_idx,
    output logic             at_end
);

    typedef struct packed {
        logic             run;
        logic [ORD_W-1:0] idx;
    } ctr_t;

    localparam logic [ORD_W-1:0] IDX_ONE = ORD_W'(1);

    ctr_t ctr_d, ctr_q;

    // The index never sets bits outside the mask, so it reaches the
    // final beat exactly when it equals the mask.
    assign at_end = ctr_q.run && (ctr_q.idx == ord_mask);

    always_comb begin
        ctr_d = ctr_q;
        if (load) begin
            ctr_d.run = 1'b1;
            ctr_d.idx = '0;
        end else if (ctr_q.run) begin
            if (halt || at_end) begin
                ctr_d.run = 1'b0;
                ctr_d.idx = '0;
            end else begin
                ctr_d.idx = ctr_q.idx + IDX_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign active   = ctr_q.run;
    assign beat_idx = ctr_q.idx;

endmodule

// File: rtl/burst_order_gen.sv
// Computes the column for one beat from the base column and the beat index.
module burst_order_gen #(
    parameter int COL_W = 9,
    parameter int ORD_W = 4
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [ORD_W-1:0] beat_idx,
    input  logic [ORD_W-1:0] ord_mask,
    input  burst_seq_pkg::order_e order,
    output logic [COL_W-1:0] col
);

    // A sum taken modulo 2^ORD_W has the same low k bits as one taken
    // modulo 2^k, so a single adder serves every burst length.
    logic [ORD_W-1:0] seq_low;
    assign seq_low = base_col[ORD_W-1:0] + beat_idx;

    for (genvar j = 0; j < COL_W; j++) begin : g_col
        if (j < ORD_W) begin : g_ord
            logic ilv_bit;
            assign ilv_bit = base_col[j] ^ beat_idx[j];
            assign col[j]  = !ord_mask[j] ? base_col[j]
                           : (order == burst_seq_pkg::ORDER_ILV) ? ilv_bit
                           : seq_low[j];
        end else begin : g_fix
            assign col[j] = base_col[j];
        end
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
    parameter int COL_W = 9,
    parameter int LEN_W = 2,
    localparam int ORD_W = 2 ** LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [LEN_W-1:0] len_code,
    input  logic             order_ilv,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_out,
    output logic             beat_valid,
    output logic             beat_last
);

    import burst_seq_pkg::*;

    typedef struct packed {
        logic [COL_W-1:0] base;
        logic [ORD_W-1:0] mask;
        order_e           order;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [ORD_W-1:0] new_mask;
    logic             run;
    logic             at_end;
    logic [ORD_W-1:0] idx;
    logic [COL_W-1:0] col_raw;

    burst_len_mask #(.LEN_W(LEN_W)) u_mask (
        .len_code (len_code),
        .ord_mask (new_mask)
    );

    // A start overrides a stop sampled at the same edge.
    burst_beat_ctr #(.ORD_W(ORD_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .halt     (burst_stop),
        .ord_mask (cfg_q.mask),
        .active   (run),
        .beat_idx (idx),
        .at_end   (at_end)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (start) begin
            cfg_d.base  = start_col;
            cfg_d.mask  = new_mask;
            cfg_d.order = order_e'(order_ilv);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{base: '0, mask: '0, order: ORDER_SEQ};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    burst_order_gen #(.COL_W(COL_W), .ORD_W(ORD_W)) u_gen (
        .base_col (cfg_q.base),
        .beat_idx (idx),
        .ord_mask (cfg_q.mask),
        .order    (cfg_q.order),
        .col      (col_raw)
    );

    assign col_out    = run ? col_raw : '0;
    assign beat_valid = run;
    assign beat_last  = at_end;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 9,
    parameter int ORD_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             burst_stop,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col_out,
    input logic             beat_valid,
    input logic             beat_last
);

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (beat_valid && col_out == $past(start_col)));

    assert_high_bits_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && $past(beat_valid) && !$past(start))
        |-> (col_out[COL_W-1:ORD_W] == $past(col_out[COL_W-1:ORD_W])));

    assert_last_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !start) |=> !beat_valid);

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !start && beat_valid) |=> !beat_valid);

    assert_start_beats_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && burst_stop) |=> beat_valid);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .ORD_W(ORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .burst_stop (burst_stop),
    .start_col  (start_col),
    .col_out    (col_out),
    .beat_valid (beat_valid),
    .beat_last  (beat_last)
);

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic [1:0] len_code = '0;
    logic       order_ilv = 1'b0;
    logic       burst_stop = 1'b0;
    logic [8:0] col_out;
    logic       beat_valid;
    logic       beat_last;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural model state
    int m_active = 0;
    int m_base = 0;
    int m_len = 2;
    int m_ilv = 0;
    int m_idx = 0;

    always #4 clk = ~clk;

    burst_col_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .len_code(len_code), .order_ilv(order_ilv), .burst_stop(burst_stop),
        .col_out(col_out), .beat_valid(beat_valid), .beat_last(beat_last)
    );

    function automatic int exp_col();
        int blk = m_base - (m_base % m_len);
        int off = m_base % m_len;
        if (m_ilv != 0) return blk + (off ^ m_idx);
        return blk + ((off + m_idx) % m_len);
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
        end
    endtask

    // Compare the current outputs, then drive one cycle of stimulus.
    task automatic cyc(input bit s, input int c, input int l, input bit i,
                       input bit p, input string tag);
        @(negedge clk);
        check(tag, "valid", int'(beat_valid), m_active);
        if (m_active != 0) begin
            check(tag, "col", int'(col_out), exp_col());
            check(tag, "last", int'(beat_last), int'(m_idx == m_len - 1));
        end else begin
            check(tag, "last", int'(beat_last), 0);
        end
        start = s; start_col = 9'(c); len_code = 2'(l); order_ilv = i; burst_stop = p;
        @(posedge clk);
        if (s) begin
            m_active = 1; m_base = c; m_len = 2 << l; m_ilv = int'(i); m_idx = 0;
        end else if (m_active != 0) begin
            if (p || m_idx == m_len - 1) begin
                m_active = 0; m_idx = 0;
            end else begin
                m_idx++;
            end
        end
    endtask

    task automatic burst(input int c, input int l, input bit i, input int idle, input string tag);
        cyc(1, c, l, i, 0, tag);
        for (int k = 0; k < idle; k++) cyc(0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset valid", int'(beat_valid), 0);
        check("R1", "reset last", int'(beat_last), 0);
        check("R1", "reset col", int'(col_out), 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, "R1");
        cyc(0, 0, 0, 0, 0, "R1");

        // R3: every length, run past the end
        for (int l = 0; l < 4; l++) burst(0, l, 0, (2 << l) + 2, "R3");
        // R2 / R4: sequential wrap, including high column bits (R6)
        burst(5, 2, 0, 10, "R4");
        burst(9'h1AD, 3, 0, 18, "R4");
        burst(9'h0F3, 1, 0, 6, "R6");
        burst(9'h101, 0, 0, 3, "R2");
        // R5: interleaved
        burst(5, 2, 1, 10, "R5");
        burst(9'h1F3, 3, 1, 18, "R5");
        burst(9'h0AE, 1, 1, 6, "R5");
        burst(9'h033, 0, 1, 3, "R6");
        // R7: last flag across back-to-back lengths
        burst(9'h047, 2, 0, 9, "R7");
        // R8: stop mid-burst, and stop while idle
        burst(9'h0C2, 3, 0, 3, "R8");
        cyc(0, 0, 0, 0, 1, "R8");
        cyc(0, 0, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 1, "R8");
        cyc(0, 0, 0, 0, 1, "R8");
        cyc(0, 0, 0, 0, 0, "R8");
        // R9: restart mid-burst, then start during the final beat
        burst(5, 2, 0, 2, "R9");
        burst(9'h1F0, 3, 1, 4, "R9");
        burst(9'h012, 1, 0, 3, "R9");
        burst(9'h0E9, 2, 1, 3, "R9");
        burst(9'h0E9, 0, 0, 1, "R9");
        burst(9'h07B, 1, 1, 6, "R9");
        // R10: start together with stop
        burst(9'h150, 2, 0, 2, "R10");
        cyc(1, 9'h026, 1, 1, 1, "R10");
        for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, 0, "R10");

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule